// File: doc/BRIEF.md
# Multiplexed-bus register interface with block move

This block is the slave side of a peripheral's 8-bit microprocessor bus. It accepts either a multiplexed bus, where the register address is sent on the shared data lines and held by the falling edge of an address-latch strobe, or a separate-address bus, where the latch strobe stays high and a 4-bit address arrives on its own pins. All bus strobes are brought into the core clock domain by two-flop synchronizers. The block then decodes each access into a register-file write, a register read or a FIFO transfer.

Register 0 is the control register and is held inside the block. Its bit 3 enables block move. When that bit is set and data line 6 is high during a multiplexed address phase, every later write pushes its byte into the transmit FIFO and every later read returns the receive FIFO head and pops it. This lasts until the next address phase that has line 6 low, or until the bit is cleared. The other registers, both FIFOs and the serial engine live outside the block. The block reaches them through a write port, a read-address/read-data pair, and push and pop strobes.

Top module: `mbus_regif`

## Requirements
- R1: In multiplexed mode (sep_mode=0), the falling edge of `ale` latches the register address from `ad_in[3:0]` whatever the level of `cs_n`. The latched address governs later accesses until the next falling edge.
- R2: In separate-address mode (sep_mode=1, `ale` held high), the register address is taken from `addr_in` and not from any latched value.
- R3: A write needs `cs_n` and `wr_n` both low. The byte on `ad_in` is taken at the rising (trailing) edge of `wr_n`, and the resulting one-cycle strobe is high in the clock cycle that follows the third rising clock edge after that trailing edge.
- R4: While `cs_n` and `rd_n` are both low, `ad_oe` is 1 and `ad_out` carries the addressed register. Address 0 returns the control register, whose bit 3 is the block-move enable.
- R5: While `cs_n` is high, `ad_oe` is 0.
- R6: With control bit 3 set and `ad_in[6]` high at the multiplexed address phase, each later write raises `tx_push` with `tx_data` equal to the written byte and makes no register write. Each later read shows `rx_data` on `ad_out` and raises `rx_pop`.
- R7: With `ad_in[6]` low at the address phase, or with control bit 3 clear, accesses use normal register addressing.
- R8: Asserting `rst_n` low forces `ad_oe` to 0 at once, with no clock edge needed. It clears the control register to 0x00 and drops all strobes.
- R9: Each completed access produces exactly one strobe (`reg_wr_en`, `tx_push` or `rx_pop`), one clock wide. A register read produces none.
- R10: Addresses at or above NUM_REGS (default 12) read back as 0x00, and writes to them raise no strobe and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sep_mode | input | 1 | 1 selects separate-address mode |
| ale | input | 1 | Address latch strobe, falling edge latches |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr_in | input | 4 | Address pins for separate-address mode |
| ad_in | input | 8 | Data/address lines as seen by the block |
| ad_out | output | 8 | Read data driven toward the bus |
| ad_oe | output | 1 | Output enable of the bus driver |
| reg_wr_en | output | 1 | Register-file write strobe |
| reg_wr_addr | output | 4 | Register-file write address |
| reg_wr_data | output | 8 | Register-file write data |
| reg_rd_addr | output | 4 | Register-file read address |
| reg_rd_data | input | 8 | Register-file read data |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_data | output | 8 | Byte pushed into the transmit FIFO |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| rx_data | input | 8 | Receive FIFO head byte |

## Verification
Every bus strobe passes through two synchronizer flops and an edge-detect flop. An address latch, a control-register update or a strobe therefore takes effect on the third rising clock edge after the bus edge that causes it. The bench holds the address and data lines stable for four clocks after each bus edge. Write tasks sample at the falling clock edge after the second rising edge and expect no strobe there, then sample one clock later and expect exactly one. `ad_oe` and `ad_out` are combinational from the bus pins and the latched address, so reads are sampled a few clocks into the strobe's low phase. The asynchronous reset is checked one time unit after `rst_n` falls, with no clock edge in between.

// File: rtl/mbus_regif_pkg.sv
package mbus_regif_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int BM_BIT   = 3;
  localparam int FLAG_BIT = 6;
  localparam logic [DATA_W-1:0] CTRL_RST = '0;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic ale;
    logic cs_n;
    logic rd_n;
    logic wr_n;
  } bus_ctl_t;
endpackage

// File: rtl/mbus_regif_sync.sv
module mbus_regif_sync #(
  parameter int               WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
      prev_q   <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign q      = stage2_q;
  assign q_prev = prev_q;
endmodule

// File: rtl/mbus_regif_addr_latch.sv
module mbus_regif_addr_latch
  import mbus_regif_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sep_mode,
  input  logic  ale_fall,
  input  byte_t ad_in,
  input  addr_t addr_in,
  output addr_t cur_addr,
  output logic  bm_flag
);
  addr_t addr_q, addr_d;
  logic  flag_q, flag_d;
  logic  capture_en;

  assign capture_en = ale_fall && !sep_mode;

  always_comb begin
    addr_d = addr_q;
    flag_d = flag_q;
    if (capture_en) begin
      addr_d = ad_in[ADDR_W-1:0];
      flag_d = ad_in[FLAG_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      flag_q <= 1'b0;
    end else if (capture_en) begin
      addr_q <= addr_d;
      flag_q <= flag_d;
    end
  end

  assign cur_addr = sep_mode ? addr_in : addr_q;
  assign bm_flag  = flag_q && !sep_mode;
endmodule

// File: rtl/mbus_regif_access.sv
module mbus_regif_access
  import mbus_regif_pkg::*;
#(
  parameter int NUM_REGS = 12
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_evt,
  input  logic  rd_evt,
  input  logic  bm_flag,
  input  addr_t cur_addr,
  input  byte_t ad_in,
  output byte_t ctrl,
  output logic  bm_active,
  output logic  reg_wr_en,
  output addr_t reg_wr_addr,
  output byte_t reg_wr_data,
  output logic  tx_push,
  output byte_t tx_data,
  output logic  rx_pop
);
  localparam int LAST_MAPPED = NUM_REGS - 1;

  byte_t ctrl_q, ctrl_d;
  logic  wen_q, wen_d, push_q, push_d, pop_q, pop_d;
  addr_t waddr_q, waddr_d;
  byte_t wdata_q, wdata_d;
  logic  mapped, is_ctrl;

  assign bm_active = bm_flag && ctrl_q[BM_BIT];
  assign mapped    = (int'(cur_addr) <= LAST_MAPPED);
  assign is_ctrl   = (cur_addr == '0);

  always_comb begin
    ctrl_d  = ctrl_q;
    wen_d   = 1'b0;
    push_d  = 1'b0;
    pop_d   = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    if (wr_evt) begin
      wdata_d = ad_in;
      if (bm_active) begin
        push_d = 1'b1;
      end else if (is_ctrl) begin
        ctrl_d = ad_in;
      end else if (mapped) begin
        wen_d   = 1'b1;
        waddr_d = cur_addr;
      end
    end else if (rd_evt && bm_active) begin
      pop_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      wen_q   <= 1'b0;
      push_q  <= 1'b0;
      pop_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      wen_q   <= wen_d;
      push_q  <= push_d;
      pop_q   <= pop_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign ctrl        = ctrl_q;
  assign reg_wr_en   = wen_q;
  assign reg_wr_addr = waddr_q;
  assign reg_wr_data = wdata_q;
  assign tx_push     = push_q;
  assign tx_data     = wdata_q;
  assign rx_pop      = pop_q;
endmodule

// File: rtl/mbus_regif.sv
module mbus_regif
  import mbus_regif_pkg::*;
#(
  parameter int NUM_REGS = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sep_mode,
  input  logic       ale,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [3:0] addr_in,
  input  logic [7:0] ad_in,
  output logic [7:0] ad_out,
  output logic       ad_oe,
  output logic       reg_wr_en,
  output logic [3:0] reg_wr_addr,
  output logic [7:0] reg_wr_data,
  output logic [3:0] reg_rd_addr,
  input  logic [7:0] reg_rd_data,
  output logic       tx_push,
  output logic [7:0] tx_data,
  output logic       rx_pop,
  input  logic [7:0] rx_data
);
  localparam int LAST_MAPPED = NUM_REGS - 1;

  logic     rst_meta_q, rst_core_q;
  bus_ctl_t pins, s_now, s_prev;
  logic     ale_fall, wr_evt, rd_evt;
  addr_t    cur_addr;
  logic     bm_flag, bm_active;
  byte_t    ctrl;
  byte_t    rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_q <= rst_meta_q;
    end
  end

  assign pins = '{ale: ale, cs_n: cs_n, rd_n: rd_n, wr_n: wr_n};

  mbus_regif_sync #(.WIDTH(4), .RST_VAL(4'b1111)) u_sync (
    .clk    (clk),
    .rst_n  (rst_core_q),
    .d      (pins),
    .q      (s_now),
    .q_prev (s_prev)
  );

  assign ale_fall = s_prev.ale && !s_now.ale;
  assign wr_evt   = !s_prev.wr_n && s_now.wr_n && !s_now.cs_n;
  assign rd_evt   = !s_prev.rd_n && s_now.rd_n && !s_now.cs_n;

  mbus_regif_addr_latch u_addr (
    .clk      (clk),
    .rst_n    (rst_core_q),
    .sep_mode (sep_mode),
    .ale_fall (ale_fall),
    .ad_in    (ad_in),
    .addr_in  (addr_in),
    .cur_addr (cur_addr),
    .bm_flag  (bm_flag)
  );

  mbus_regif_access #(.NUM_REGS(NUM_REGS)) u_access (
    .clk         (clk),
    .rst_n       (rst_core_q),
    .wr_evt      (wr_evt),
    .rd_evt      (rd_evt),
    .bm_flag     (bm_flag),
    .cur_addr    (cur_addr),
    .ad_in       (ad_in),
    .ctrl        (ctrl),
    .bm_active   (bm_active),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .tx_push     (tx_push),
    .tx_data     (tx_data),
    .rx_pop      (rx_pop)
  );

  always_comb begin
    if (bm_active)                          rd_mux = rx_data;
    else if (cur_addr == '0)                rd_mux = ctrl;
    else if (int'(cur_addr) <= LAST_MAPPED) rd_mux = reg_rd_data;
    else                                    rd_mux = '0;
  end

  assign reg_rd_addr = cur_addr;
  assign ad_out      = rd_mux;
  assign ad_oe       = rst_n && !cs_n && !rd_n;
endmodule

// File: rtl/mbus_regif_checker.sv
module mbus_regif_checker #(
  parameter int NUM_REGS = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       ad_oe,
  input logic [7:0] ad_out,
  input logic [3:0] reg_rd_addr,
  input logic       reg_wr_en,
  input logic [3:0] reg_wr_addr,
  input logic       tx_push,
  input logic       rx_pop,
  input logic       bm_active
);
  p_tristate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !ad_oe);

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_en, tx_push, rx_pop}));

  p_push_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !tx_push);

  p_pop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !rx_pop);

  p_wen_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  p_push_needs_bm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> $past(bm_active));

  p_wr_mapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_wr_addr != 4'd0 && int'(reg_wr_addr) < NUM_REGS));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && !bm_active && int'(reg_rd_addr) >= NUM_REGS) |-> ad_out == 8'h00);
endmodule

bind mbus_regif mbus_regif_checker #(.NUM_REGS(NUM_REGS)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .ad_oe       (ad_oe),
  .ad_out      (ad_out),
  .reg_rd_addr (reg_rd_addr),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_addr (reg_wr_addr),
  .tx_push     (tx_push),
  .rx_pop      (rx_pop),
  .bm_active   (bm_active)
);

// File: tb/mbus_regif_bench.sv
module mbus_regif_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sep_mode, ale, cs_n, rd_n, wr_n;
  logic [3:0] addr_in;
  logic [7:0] ad_in;
  logic [7:0] ad_out;
  logic       ad_oe;
  logic       reg_wr_en;
  logic [3:0] reg_wr_addr;
  logic [7:0] reg_wr_data;
  logic [3:0] reg_rd_addr;
  logic [7:0] reg_rd_data;
  logic       tx_push;
  logic [7:0] tx_data;
  logic       rx_pop;
  logic [7:0] rx_data;

  int tests = 0;
  int fails = 0;
  int wen_cnt = 0, push_cnt = 0, pop_cnt = 0;
  logic [7:0] last_tx = 8'h00;
  logic [7:0] regmem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_regif u_mbus_regif (
    .clk(clk), .rst_n(rst_n), .sep_mode(sep_mode), .ale(ale), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .addr_in(addr_in), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop), .rx_data(rx_data)
  );

  assign reg_rd_data = regmem[reg_rd_addr];

  always @(posedge clk) begin
    if (rst_n) begin
      if (reg_wr_en) begin
        regmem[reg_wr_addr] <= reg_wr_data;
        wen_cnt <= wen_cnt + 1;
      end
      if (tx_push) begin
        push_cnt <= push_cnt + 1;
        last_tx  <= tx_data;
      end
      if (rx_pop) pop_cnt <= pop_cnt + 1;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [3:0] a, input logic flag);
    ad_in = {1'b0, flag, 2'b00, a};
    ale = 1'b1;
    clocks(2);
    ale = 1'b0;
    clocks(4);
  endtask

  // write with exact-cycle strobe check (R3, R9)
  task automatic bus_write(input logic [7:0] d, input logic expect_strobe, input string req);
    cs_n = 1'b0;
    ad_in = d;
    wr_n = 1'b0;
    clocks(4);
    wr_n = 1'b1;
    clocks(2);
    check({req, " no strobe before third edge"}, int'(reg_wr_en | tx_push), 0);
    clocks(1);
    check({req, " strobe after third edge"}, int'(reg_wr_en | tx_push), int'(expect_strobe));
    clocks(2);
    cs_n = 1'b1;
    clocks(2);
  endtask

  task automatic bus_read(output logic [7:0] d, output logic oe);
    cs_n = 1'b0;
    rd_n = 1'b0;
    clocks(3);
    d  = ad_out;
    oe = ad_oe;
    rd_n = 1'b1;
    clocks(4);
    cs_n = 1'b1;
    clocks(2);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    logic oe;
    check("R8 oe after reset", int'(ad_oe), 0);
    check("R8 strobes after reset", int'({reg_wr_en, tx_push, rx_pop}), 0);
    addr_phase(4'd0, 1'b0);
    bus_read(d, oe);
    check("R8 ctrl reset value", int'(d), 8'h00);
    check("R4 oe during read", int'(oe), 1);
  endtask

  task automatic t_mux_write_read();
    logic [7:0] d;
    logic oe;
    int w0;
    w0 = wen_cnt;
    addr_phase(4'd5, 1'b0);
    bus_write(8'hA5, 1'b1, "R3");
    check("R9 one reg write", wen_cnt - w0, 1);
    check("R3 reg5 written", int'(regmem[5]), 8'hA5);
    bus_read(d, oe);
    check("R4 read reg5", int'(d), 8'hA5);
    check("R9 read makes no pop", pop_cnt, 0);
  endtask

  task automatic t_ale_without_cs();
    logic [7:0] d;
    logic oe;
    regmem[7] = 8'h3E;
    addr_phase(4'd7, 1'b0);   // cs_n stays high during address phase
    bus_read(d, oe);
    check("R1 latch while cs high", int'(d), 8'h3E);
    addr_phase(4'd5, 1'b0);
    bus_read(d, oe);
    check("R1 new latch replaces old", int'(d), 8'hA5);
  endtask

  task automatic t_tristate();
    cs_n = 1'b1;
    rd_n = 1'b0;
    clocks(2);
    check("R5 oe low with cs high", int'(ad_oe), 0);
    rd_n = 1'b1;
    clocks(2);
  endtask

  task automatic t_sep_mode();
    logic [7:0] d;
    logic oe;
    sep_mode = 1'b1;
    ale = 1'b1;
    addr_in = 4'd9;
    clocks(2);
    bus_write(8'h3C, 1'b1, "R2");
    check("R2 reg9 written", int'(regmem[9]), 8'h3C);
    addr_in = 4'd5;
    bus_read(d, oe);
    check("R2 read follows addr pins", int'(d), 8'hA5);
    ale = 1'b0;
    sep_mode = 1'b0;
    clocks(4);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    logic oe;
    int w0;
    regmem[14] = 8'h55;
    w0 = wen_cnt;
    addr_phase(4'd14, 1'b0);
    bus_write(8'h77, 1'b0, "R10");
    check("R10 no reg write", wen_cnt - w0, 0);
    check("R10 no push", push_cnt, 0);
    bus_read(d, oe);
    check("R10 unmapped reads zero", int'(d), 8'h00);
    addr_phase(4'd0, 1'b0);
    bus_read(d, oe);
    check("R10 ctrl untouched", int'(d), 8'h00);
  endtask

  task automatic t_block_move();
    logic [7:0] d;
    logic oe;
    int w0;
    addr_phase(4'd0, 1'b0);
    bus_write(8'h08, 1'b0, "R4");
    bus_read(d, oe);
    check("R4 ctrl reads back", int'(d), 8'h08);
    w0 = wen_cnt;
    addr_phase(4'd0, 1'b1);
    bus_write(8'h11, 1'b1, "R6");
    check("R6 first push", push_cnt, 1);
    check("R6 pushed byte", int'(last_tx), 8'h11);
    bus_write(8'h22, 1'b1, "R6");
    check("R9 second push", push_cnt, 2);
    check("R6 second byte", int'(last_tx), 8'h22);
    check("R6 no reg write in block move", wen_cnt - w0, 0);
    rx_data = 8'h5A;
    bus_read(d, oe);
    check("R6 read from rx", int'(d), 8'h5A);
    check("R9 one pop", pop_cnt, 1);
  endtask

  task automatic t_bm_off_paths();
    logic [7:0] d;
    logic oe;
    addr_phase(4'd5, 1'b0);
    bus_read(d, oe);
    check("R7 flag low gives register", int'(d), 8'hA5);
    check("R7 no pop", pop_cnt, 1);
    addr_phase(4'd0, 1'b0);
    bus_write(8'h00, 1'b0, "R7");
    addr_phase(4'd5, 1'b1);
    bus_read(d, oe);
    check("R7 bm clear gives register", int'(d), 8'hA5);
    check("R7 no pop with bm clear", pop_cnt, 1);
  endtask

  task automatic t_async_reset();
    logic [7:0] d;
    logic oe;
    addr_phase(4'd0, 1'b0);
    bus_write(8'h08, 1'b0, "R8");
    cs_n = 1'b0;
    rd_n = 1'b0;
    clocks(1);
    #1;
    rst_n = 1'b0;
    #1;
    check("R8 oe drops without clock", int'(ad_oe), 0);
    rd_n = 1'b1;
    cs_n = 1'b1;
    clocks(2);
    rst_n = 1'b1;
    clocks(4);
    addr_phase(4'd0, 1'b0);
    bus_read(d, oe);
    check("R8 ctrl cleared by reset", int'(d), 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regmem[i] = 8'h00;
    rst_n = 1'b0;
    sep_mode = 1'b0;
    ale = 1'b0;
    cs_n = 1'b1;
    rd_n = 1'b1;
    wr_n = 1'b1;
    addr_in = 4'd0;
    ad_in = 8'h00;
    rx_data = 8'h00;
    clocks(3);
    rst_n = 1'b1;
    clocks(5);
    t_reset();
    t_mux_write_read();
    t_ale_without_cs();
    t_tristate();
    t_sep_mode();
    t_unmapped();
    t_block_move();
    t_bm_off_paths();
    t_async_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule